// File: doc/BRIEF.md
# CCD Line Pixel Classifier with Parity Black Clamp

This block sits behind the converter of a linear CCD readout chain and sees one digitised sample on every clock, where the clock is the pixel clock. A strobe from the sensor timing generator marks the first sample of each line. Within a line, the block tracks the position of each sample and sorts it into one of three kinds: a leading or trailing dummy, an optical-black reference, or an effective pixel.

The reference samples sit inside the leading dummy stretch. They are summed separately for even and odd line positions, and each sum is reduced to an average rounded to nearest. Every effective pixel then has the black level of its own parity subtracted, with the result floored at zero. Only effective pixels raise the valid strobe, and each comes with its 1-based pixel number. Converter control, gain correction and analog offset handling belong to other blocks.

The default line has 3066 positions: 56 leading dummies at indices 0 to 55, then 3000 effective pixels at indices 56 to 3055, then 10 trailing dummies. The black reference covers indices 24 to 53.

Top module: `ccd_line_clamp`

## Requirements
- R1: While rst_ni is low, and until the first output, valid_o is 0, pix_idx_o is 0 and data_o is 0.
- R2: Samples that arrive before the first line_start_i pulse after reset never produce valid_o.
- R3: A sample taken with line_start_i high has index 0, and each following sample has the next index. The sample at index 56+k-1 (k = 1..3000) appears on the outputs two clock cycles after it was presented, with valid_o high and pix_idx_o = k. No other sample raises valid_o.
- R4: The even black level is round-to-nearest of the mean of the samples at indices 24, 26, …, 52 of the line. It is applied to effective pixels with an even pixel number k.
- R5: The odd black level is formed the same way from indices 25, 27, …, 53. It is applied to effective pixels with an odd pixel number k.
- R6: Rounding takes floor((2·S + 15) / 30), where S is the sum of the 15 samples, so an exact half rounds up.
- R7: data_o = pix − black when pix > black; otherwise data_o = 0.
- R8: Dummy positions (indices 0–55 and 3056–3065) and samples after index 3065 that arrive without a new strobe produce no valid_o.
- R9: A line_start_i pulse in the middle of a line restarts the index at 0 with that sample. No further pixels of the abandoned line are output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, one sample per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | High together with the first sample (index 0) of a line |
| pix_i | input | DATA_W (12) | Digitised sample |
| valid_o | output | 1 | High for one cycle per corrected effective pixel |
| pix_idx_o | output | PIX_W (12) | Pixel number, 1 to 3000 |
| data_o | output | DATA_W (12) | Black-corrected pixel, floored at zero |

## Verification
The hardest case to reach is a black average whose rounding direction actually matters. Random reference samples rarely land on a remainder that separates round-to-nearest from truncation or ceiling, and the result is visible only after subtraction from later pixels. One line therefore drives reference values with sums that leave remainders of 8 and 7 out of 15, which produce averages of 101 and 100. Its effective pixels are held constant so that each parity shows its own offset. A line restarted at index 1000 and an idle gap of samples with no strobe reach the restart and the ignore paths.

// File: rtl/ccd_clamp_pkg.sv
package ccd_clamp_pkg;
  typedef enum logic [1:0] {
    RG_IDLE  = 2'd0,
    RG_DUMMY = 2'd1,
    RG_BLACK = 2'd2,
    RG_EFF   = 2'd3
  } region_e;
endpackage

// File: rtl/ccd_pos_tracker.sv
module ccd_pos_tracker
  import ccd_clamp_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int LINE_LEN  = 3066,
  parameter int OB_FIRST  = 24,
  parameter int OB_LEN    = 30,
  parameter int EFF_FIRST = 56,
  parameter int EFF_LEN   = 3000,
  localparam int IDX_W    = $clog2(LINE_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [DATA_W-1:0] pix_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] pix_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_LEN - 1);
  localparam logic [IDX_W-1:0] OB_LO    = IDX_W'(OB_FIRST);
  localparam logic [IDX_W-1:0] OB_HI    = IDX_W'(OB_FIRST + OB_LEN - 1);
  localparam logic [IDX_W-1:0] EFF_LO   = IDX_W'(EFF_FIRST);
  localparam logic [IDX_W-1:0] EFF_HI   = IDX_W'(EFF_FIRST + EFF_LEN - 1);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] pix_q;
  logic              cont;
  logic              nxt_active;
  logic [IDX_W-1:0]  nxt_idx;

  always_comb begin
    cont       = active_q && (idx_q != LAST_IDX);
    nxt_active = line_start_i || cont;
    if (line_start_i)  nxt_idx = '0;
    else if (cont)     nxt_idx = idx_q + 1'b1;
    else               nxt_idx = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      pix_q    <= '0;
    end else begin
      active_q <= nxt_active;
      idx_q    <= nxt_idx;
      pix_q    <= pix_i;
    end
  end

  always_comb begin
    if (!active_q)                              region_o = RG_IDLE;
    else if (idx_q >= OB_LO && idx_q <= OB_HI)  region_o = RG_BLACK;
    else if (idx_q >= EFF_LO && idx_q <= EFF_HI) region_o = RG_EFF;
    else                                        region_o = RG_DUMMY;
  end

  assign idx_o = idx_q;
  assign pix_o = pix_q;

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> (active_q && idx_q == '0));

  a_r8_line_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && idx_q == LAST_IDX && !line_start_i) |=> !active_q);

  a_r3_index_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && idx_q != LAST_IDX && !line_start_i) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/ccd_black_accum.sv
module ccd_black_accum
  import ccd_clamp_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int IDX_W    = 12,
  parameter int OB_FIRST = 24,
  parameter int OB_LEN   = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  region_e           region_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic [DATA_W-1:0] blk_even_o,
  output logic [DATA_W-1:0] blk_odd_o
);
  localparam int OB_HALF = OB_LEN / 2;
  localparam int SUM_W   = DATA_W + $clog2(OB_HALF + 1);
  localparam logic [IDX_W-1:0] FIRST_E = IDX_W'(OB_FIRST);
  localparam logic [IDX_W-1:0] FIRST_O = IDX_W'(OB_FIRST + 1);
  localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(OB_FIRST + OB_LEN - 1);

  function automatic logic [DATA_W-1:0] round_avg(input logic [SUM_W-1:0] s);
    logic [SUM_W+1:0] num;
    num = {1'b0, s, 1'b0} + (SUM_W+2)'(OB_HALF);
    return DATA_W'(num / (SUM_W+2)'(2 * OB_HALF));
  endfunction

  logic [SUM_W-1:0]  sum_even_q, sum_odd_q;
  logic [SUM_W-1:0]  add_val;
  logic [DATA_W-1:0] blk_even_q, blk_odd_q;
  logic              in_black, is_last;

  assign in_black = (region_i == RG_BLACK);
  assign is_last  = in_black && (idx_i == LAST_I);
  assign add_val  = SUM_W'(pix_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_even_q <= '0;
      sum_odd_q  <= '0;
      blk_even_q <= '0;
      blk_odd_q  <= '0;
    end else begin
      if (in_black && !idx_i[0])
        sum_even_q <= (idx_i == FIRST_E) ? add_val : sum_even_q + add_val;
      if (in_black && idx_i[0])
        sum_odd_q  <= (idx_i == FIRST_O) ? add_val : sum_odd_q + add_val;
      if (is_last) begin
        blk_even_q <= round_avg(sum_even_q);
        blk_odd_q  <= round_avg(sum_odd_q + add_val);
      end
    end
  end

  assign blk_even_o = blk_even_q;
  assign blk_odd_o  = blk_odd_q;

  // levels only move at the close of the black region
  a_r4_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_last |=> ($stable(blk_even_q) && $stable(blk_odd_q)));

  a_r5_sum_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_black && idx_i == FIRST_O) |=> (sum_odd_q == SUM_W'($past(pix_i))));
endmodule

// File: rtl/ccd_clamp_sub.sv
module ccd_clamp_sub
  import ccd_clamp_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int IDX_W     = 12,
  parameter int PIX_W     = 12,
  parameter int EFF_FIRST = 56,
  parameter int EFF_LEN   = 3000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  region_e           region_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] pix_i,
  input  logic [DATA_W-1:0] blk_even_i,
  input  logic [DATA_W-1:0] blk_odd_i,
  output logic              valid_o,
  output logic [PIX_W-1:0]  pix_idx_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [IDX_W-1:0] EFF_BASE = IDX_W'(EFF_FIRST - 1);

  logic [IDX_W-1:0]  pnum;
  logic [DATA_W-1:0] blk, diff;
  logic              valid_q;
  logic [PIX_W-1:0]  pidx_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    pnum = idx_i - EFF_BASE;
    blk  = pnum[0] ? blk_odd_i : blk_even_i;
    diff = (pix_i > blk) ? (pix_i - blk) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pidx_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= (region_i == RG_EFF);
      if (region_i == RG_EFF) begin
        pidx_q <= PIX_W'(pnum);
        data_q <= diff;
      end
    end
  end

  assign valid_o   = valid_q;
  assign pix_idx_o = pidx_q;
  assign data_o    = data_q;

  a_r7_never_above_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_i == RG_EFF) |=> (data_q <= $past(pix_i)));

  a_r3_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (pidx_q >= PIX_W'(1) && pidx_q <= PIX_W'(EFF_LEN)));
endmodule

// File: rtl/ccd_line_clamp.sv
module ccd_line_clamp
  import ccd_clamp_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int OB_FIRST  = 24,
  parameter int OB_LEN    = 30,
  parameter int EFF_FIRST = 56,
  parameter int EFF_LEN   = 3000,
  parameter int TRAIL_LEN = 10,
  localparam int LINE_LEN = EFF_FIRST + EFF_LEN + TRAIL_LEN,
  localparam int IDX_W    = $clog2(LINE_LEN),
  localparam int PIX_W    = $clog2(EFF_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic              valid_o,
  output logic [PIX_W-1:0]  pix_idx_o,
  output logic [DATA_W-1:0] data_o
);
  region_e           s1_region;
  logic [IDX_W-1:0]  s1_idx;
  logic [DATA_W-1:0] s1_pix;
  logic [DATA_W-1:0] blk_even, blk_odd;

  ccd_pos_tracker #(
    .DATA_W(DATA_W), .LINE_LEN(LINE_LEN), .OB_FIRST(OB_FIRST), .OB_LEN(OB_LEN),
    .EFF_FIRST(EFF_FIRST), .EFF_LEN(EFF_LEN)
  ) u_track (
    .clk_i, .rst_ni, .line_start_i, .pix_i,
    .region_o(s1_region), .idx_o(s1_idx), .pix_o(s1_pix)
  );

  ccd_black_accum #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .OB_FIRST(OB_FIRST), .OB_LEN(OB_LEN)
  ) u_black (
    .clk_i, .rst_ni, .region_i(s1_region), .idx_i(s1_idx), .pix_i(s1_pix),
    .blk_even_o(blk_even), .blk_odd_o(blk_odd)
  );

  ccd_clamp_sub #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .PIX_W(PIX_W), .EFF_FIRST(EFF_FIRST), .EFF_LEN(EFF_LEN)
  ) u_clamp (
    .clk_i, .rst_ni, .region_i(s1_region), .idx_i(s1_idx), .pix_i(s1_pix),
    .blk_even_i(blk_even), .blk_odd_i(blk_odd),
    .valid_o, .pix_idx_o, .data_o
  );

  a_r3_consecutive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> (pix_idx_o == $past(pix_idx_o) + 1'b1));

  a_r2_needs_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(s1_region) == RG_EFF));
endmodule

// File: tb/ccd_line_clamp_tb.sv
module ccd_line_clamp_tb;
  localparam int DATA_W = 12;
  localparam int PIX_W  = 12;
  localparam int OB_LO  = 24;
  localparam int OB_HI  = 53;
  localparam int EFF_LO = 56;
  localparam int EFF_N  = 3000;
  localparam int LINE_N = 3066;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic [DATA_W-1:0] pix = '0;
  logic valid;
  logic [PIX_W-1:0] pidx;
  logic [DATA_W-1:0] dout;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int unexpected = 0;
  bit done = 0;

  int    q_idx[$];
  int    q_dat[$];
  int    q_cyc[$];
  string q_tag[$];

  int sum_e = 0, sum_o = 0;
  int blk_e = 0, blk_o = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ccd_line_clamp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start), .pix_i(pix),
    .valid_o(valid), .pix_idx_o(pidx), .data_o(dout)
  );

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid) begin
      checks++;
      if (q_idx.size() == 0) begin
        errors++;
        unexpected++;
        $display("FAIL R2/R8 unexpected valid: idx %0d data %0d, expected none", pidx, dout);
      end else begin
        int ei, ed, ec;
        string et;
        ei = q_idx.pop_front(); ed = q_dat.pop_front();
        ec = q_cyc.pop_front(); et = q_tag.pop_front();
        if (pidx != ei || dout != ed || cyc != ec) begin
          errors++;
          $display("FAIL %s R3: idx %0d data %0d cyc %0d, expected idx %0d data %0d cyc %0d",
                   et, pidx, dout, cyc, ei, ed, ec);
        end
      end
    end
  end

  function automatic int sample(input int mode, input int seed, input int idx);
    if (idx >= OB_LO && idx <= OB_HI) begin
      if (mode == 2) return (idx == 30) ? 108 : ((idx == 31) ? 107 : 100);
      return 180 + ((idx * 37 + seed) % 41);
    end
    if (mode == 2) return 1000;
    if (mode == 1) return (idx * 7 + seed) % 400;
    return (idx * 131 + seed * 17) % 4096;
  endfunction

  task automatic drive(input logic ls, input int v);
    @(negedge clk);
    line_start = ls;
    pix = DATA_W'(v);
  endtask

  // mode 0 varied, 1 clamp-heavy, 2 rounding, 3 after restart
  task automatic run_line(input int mode, input int seed, input int cut);
    for (int i = 0; i < cut; i++) begin
      int v;
      v = sample(mode == 3 ? 0 : mode, seed, i);
      drive(i == 0, v);
      if (i >= OB_LO && i <= OB_HI) begin
        if (i % 2 == 0) sum_e = (i == OB_LO) ? v : sum_e + v;
        else            sum_o = (i == OB_LO + 1) ? v : sum_o + v;
        if (i == OB_HI) begin
          blk_e = (2 * sum_e + 15) / 30;
          blk_o = (2 * sum_o + 15) / 30;
        end
      end
      if (i >= EFF_LO && i < EFF_LO + EFF_N) begin
        int k, b, e;
        string t;
        k = i - EFF_LO + 1;
        b = (k % 2 == 1) ? blk_o : blk_e;
        e = (v > b) ? v - b : 0;
        if (mode == 2)      t = "R6";
        else if (mode == 3) t = "R9";
        else if (v <= b)    t = "R7";
        else if (k % 2)     t = "R5";
        else                t = "R4";
        q_idx.push_back(k); q_dat.push_back(e);
        q_cyc.push_back(cyc + 2); q_tag.push_back(t);
      end
    end
  endtask

  task automatic idle(input int n, input int seed);
    for (int i = 0; i < n; i++) drive(1'b0, (i * 53 + seed) % 4096);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int u0;
    repeat (3) @(negedge clk);
    checks++;
    if (valid !== 1'b0 || pidx !== '0 || dout !== '0) begin
      errors++;
      $display("FAIL R1 reset: valid %0b idx %0d data %0d, expected 0 0 0", valid, pidx, dout);
    end
    rst_n = 1'b1;

    // R2: garbage before any strobe
    u0 = unexpected;
    idle(200, 3);
    repeat (3) @(negedge clk);
    checks++;
    if (unexpected != u0) begin
      errors++;
      $display("FAIL R2 valid before first strobe: %0d, expected 0", unexpected - u0);
    end

    run_line(2, 0, LINE_N);     // R6 rounding
    run_line(0, 5, LINE_N);     // R4 R5
    run_line(1, 9, LINE_N);     // R7 clamp

    // R8: samples past line end without strobe
    u0 = unexpected;
    idle(300, 11);
    repeat (3) @(negedge clk);
    checks++;
    if (unexpected != u0) begin
      errors++;
      $display("FAIL R8 valid after line end: %0d, expected 0", unexpected - u0);
    end

    run_line(0, 13, 1000);      // abandoned mid-line
    run_line(3, 21, LINE_N);    // R9 restart
    run_line(0, 2, LINE_N);

    idle(20, 1);
    checks++;
    if (q_idx.size() != 0) begin
      errors++;
      $display("FAIL R3 missing outputs: %0d pending, expected 0", q_idx.size());
    end
    finish_run();
  end
endmodule